// File: doc/BRIEF.md
# PLL Output Frequency Calculator

This block evaluates the output frequency of a clock synthesizer from the reference frequency and the packed divider-control words that configure the synthesizer. A caller presents the reference frequency, the divider word, the fraction word and a mode select, then pulses a start strobe. The block computes the result exactly in integer arithmetic and returns it with a one-cycle done strobe. An error flag marks a configuration whose pre-divider is zero.

Two modes exist. In integer mode the result is the reference times the multiplier, divided by the pre-divider shifted left by the post-divider exponent. In fractional mode a signed 16-bit fraction extends the multiplier by 1/65536 steps, and the divisor is scaled by the same 65536. The datapath is sequential. A shift-add multiplier takes one reference bit per cycle. A restoring shift-subtract divider then takes one quotient bit per cycle over a 64-bit dividend.

Top module: `pll_freq_calc`

## Requirements
- R1: From the divider word, the multiplier M is bits 21:12, the pre-divider P is bits 9:4 and the exponent S is bits 2:0. The fraction K is bits 15:0 of the fraction word. All other bits of both words have no effect on the result.
- R2: In integer mode (frac_mode_i = 0) the result is floor(ref * M / (P << S)).
- R3: In fractional mode (frac_mode_i = 1), K is a signed 16-bit value. The result is ref * (M*65536 + K) / ((P*65536) << S), truncated toward zero. It is returned as a 64-bit two's-complement value.
- R4: If P is zero, done_o and err_o are both high in the cycle after start is accepted, freq_o is zero, and no division takes place.
- R5: Each accepted start produces exactly one done_o pulse, one cycle long. freq_o changes only in a cycle in which done_o is high.
- R6: A start_i that arrives while a computation is in progress is ignored. It produces no extra done_o and does not alter the pending result.
- R7: After reset, done_o, err_o and freq_o are all zero.
- R8: err_o is high only together with done_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start strobe, accepted only when idle |
| frac_mode_i | input | 1 | 0 = integer mode, 1 = fractional mode |
| ref_freq_i | input | REF_W | Reference frequency |
| div_word_i | input | 32 | Divider-control word (M, P, S fields) |
| frac_word_i | input | 32 | Fraction word (K field) |
| freq_o | output | 64 | Computed frequency, two's complement |
| done_o | output | 1 | One-cycle result-valid strobe |
| err_o | output | 1 | Zero pre-divider flag, valid with done_o |

## Verification
The bench builds the block with REF_W = 8. This shortens the multiply phase to eight cycles, so each computation costs under 80 cycles. That brings a full sweep of every pre-divider value against every post-divider exponent within reach in integer mode. It also allows several hundred fractional cases with both positive and negative fractions, including results that come out negative. Unused bits of both words are driven to ones throughout, so field decoding is checked on every vector. A start strobe with a zero pre-divider is issued mid-computation to show that it is ignored.

// File: rtl/pll_freq_pkg.sv
package pll_freq_pkg;
    localparam int WORD_W  = 32;
    localparam int M_LSB   = 12;
    localparam int M_W     = 10;
    localparam int P_LSB   = 4;
    localparam int P_W     = 6;
    localparam int S_LSB   = 0;
    localparam int S_W     = 3;
    localparam int K_W     = 16;
    localparam int FRAC_SH = 16;
    localparam int PROD_W  = 64;
    localparam int MAG_W   = M_W + K_W + 1;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_MUL,
        ST_DIV
    } calc_state_e;
endpackage

// File: rtl/pll_freq_mul.sv
// Shift-add multiplier: one bit of the A operand per cycle.
module pll_freq_mul #(
    parameter int A_W = 32,
    parameter int W   = 64
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           go_i,
    input  logic [A_W-1:0] a_i,
    input  logic [W-1:0]   b_i,
    output logic           done_o,
    output logic [W-1:0]   prod_o
);
    localparam int CW = $clog2(A_W + 1);

    typedef struct packed {
        logic [A_W-1:0] a;
        logic [W-1:0]   b;
        logic [W-1:0]   acc;
        logic [CW-1:0]  cnt;
        logic           busy;
        logic           done;
    } mul_state_t;

    mul_state_t q, d;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (go_i) begin
            d.a    = a_i;
            d.b    = b_i;
            d.acc  = '0;
            d.cnt  = CW'(A_W);
            d.busy = 1'b1;
        end else if (q.busy) begin
            if (q.a[0]) d.acc = q.acc + q.b;
            d.a   = q.a >> 1;
            d.b   = q.b << 1;
            d.cnt = q.cnt - 1'b1;
            if (q.cnt == CW'(1)) begin
                d.busy = 1'b0;
                d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign done_o = q.done;
    assign prod_o = q.acc;
endmodule

// File: rtl/pll_freq_div.sv
// Restoring shift-subtract divider: one quotient bit per cycle.
module pll_freq_div #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go_i,
    input  logic [W-1:0] num_i,
    input  logic [W-1:0] den_i,
    output logic         done_o,
    output logic [W-1:0] quot_o
);
    localparam int CW = $clog2(W + 1);

    typedef struct packed {
        logic [W:0]    rem;
        logic [W-1:0]  num;
        logic [W-1:0]  den;
        logic [W-1:0]  quot;
        logic [CW-1:0] cnt;
        logic          busy;
        logic          done;
    } div_state_t;

    div_state_t q, d;
    logic [W:0] trial_w;

    always_comb begin
        d       = q;
        d.done  = 1'b0;
        trial_w = {q.rem[W-1:0], q.num[W-1]};
        if (go_i) begin
            d.rem  = '0;
            d.num  = num_i;
            d.den  = den_i;
            d.quot = '0;
            d.cnt  = CW'(W);
            d.busy = 1'b1;
        end else if (q.busy) begin
            d.num = q.num << 1;
            if (trial_w >= {1'b0, q.den}) begin
                d.rem  = trial_w - {1'b0, q.den};
                d.quot = {q.quot[W-2:0], 1'b1};
            end else begin
                d.rem  = trial_w;
                d.quot = {q.quot[W-2:0], 1'b0};
            end
            d.cnt = q.cnt - 1'b1;
            if (q.cnt == CW'(1)) begin
                d.busy = 1'b0;
                d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign done_o = q.done;
    assign quot_o = q.quot;
endmodule

// File: rtl/pll_freq_calc.sv
module pll_freq_calc
    import pll_freq_pkg::*;
#(
    parameter int REF_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              frac_mode_i,
    input  logic [REF_W-1:0]  ref_freq_i,
    input  logic [WORD_W-1:0] div_word_i,
    input  logic [WORD_W-1:0] frac_word_i,
    output logic [PROD_W-1:0] freq_o,
    output logic              done_o,
    output logic              err_o
);
    typedef struct packed {
        calc_state_e       st;
        logic              neg;
        logic [PROD_W-1:0] den;
        logic [PROD_W-1:0] freq;
        logic              done;
        logic              err;
    } top_state_t;

    top_state_t q, d;

    logic [M_W-1:0]    m_f;
    logic [P_W-1:0]    p_f;
    logic [S_W-1:0]    s_f;
    logic [K_W-1:0]    k_f;
    logic [MAG_W:0]    sval_w;
    logic [MAG_W:0]    mag_w;
    logic [PROD_W-1:0] den_w;
    logic              accept_w;
    logic              mul_go_w, mul_done_w, div_go_w, div_done_w;
    logic [PROD_W-1:0] prod_w, quot_w;
    logic              busy_w;

    // Field decode and signed multiplier magnitude
    always_comb begin
        m_f = div_word_i[M_LSB +: M_W];
        p_f = div_word_i[P_LSB +: P_W];
        s_f = div_word_i[S_LSB +: S_W];
        k_f = frac_word_i[K_W-1:0];
        if (frac_mode_i)
            sval_w = {1'b0, m_f, {FRAC_SH{1'b0}}}
                   + {{(MAG_W + 1 - K_W){k_f[K_W-1]}}, k_f};
        else
            sval_w = {{(MAG_W + 1 - M_W){1'b0}}, m_f};
        mag_w = sval_w[MAG_W] ? (~sval_w + 1'b1) : sval_w;
        if (frac_mode_i)
            den_w = (PROD_W'(p_f) << FRAC_SH) << s_f;
        else
            den_w = PROD_W'(p_f) << s_f;
    end

    assign busy_w   = (q.st != ST_IDLE);
    assign accept_w = (q.st == ST_IDLE) && start_i;
    assign mul_go_w = accept_w && (p_f != '0);
    assign div_go_w = (q.st == ST_MUL) && mul_done_w;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        d.err  = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (accept_w) begin
                    if (p_f == '0) begin
                        d.done = 1'b1;
                        d.err  = 1'b1;
                        d.freq = '0;
                    end else begin
                        d.st  = ST_MUL;
                        d.neg = sval_w[MAG_W];
                        d.den = den_w;
                    end
                end
            end
            ST_MUL: begin
                if (mul_done_w) d.st = ST_DIV;
            end
            ST_DIV: begin
                if (div_done_w) begin
                    d.st   = ST_IDLE;
                    d.done = 1'b1;
                    d.freq = q.neg ? (~quot_w + 1'b1) : quot_w;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: ST_IDLE, default: '0};
        else        q <= d;
    end

    pll_freq_mul #(.A_W(REF_W), .W(PROD_W)) u_mul (
        .clk    (clk),
        .rst_n  (rst_n),
        .go_i   (mul_go_w),
        .a_i    (ref_freq_i),
        .b_i    (PROD_W'(mag_w)),
        .done_o (mul_done_w),
        .prod_o (prod_w)
    );

    pll_freq_div #(.W(PROD_W)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .go_i   (div_go_w),
        .num_i  (prod_w),
        .den_i  (q.den),
        .done_o (div_done_w),
        .quot_o (quot_w)
    );

    assign freq_o = q.freq;
    assign done_o = q.done;
    assign err_o  = q.err;
endmodule

// File: rtl/pll_freq_calc_chk.sv
module pll_freq_calc_chk
    import pll_freq_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic [WORD_W-1:0] div_word_i,
    input logic [PROD_W-1:0] freq_o,
    input logic              done_o,
    input logic              err_o,
    input logic              busy_i
);
    assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_freq_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(freq_o));

    assert_err_only_with_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> done_o);

    assert_zero_on_err_R4: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (freq_o == '0));

    assert_p0_immediate_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_i && start_i && div_word_i[P_LSB +: P_W] == '0) |=> (done_o && err_o));

    assert_done_from_job_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ($past(busy_i) || $past(start_i)));
endmodule

bind pll_freq_calc pll_freq_calc_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .div_word_i (div_word_i),
    .freq_o     (freq_o),
    .done_o     (done_o),
    .err_o      (err_o),
    .busy_i     (busy_w)
);

// File: tb/pll_freq_calc_test.sv
module pll_freq_calc_test;
    localparam int REF_W = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_i = 1'b0;
    logic              frac_mode_i = 1'b0;
    logic [REF_W-1:0]  ref_freq_i = '0;
    logic [31:0]       div_word_i = '0;
    logic [31:0]       frac_word_i = '0;
    logic [63:0]       freq_o;
    logic              done_o;
    logic              err_o;

    int vectors = 0;
    int misses  = 0;

    always #4 clk = ~clk;

    pll_freq_calc #(.REF_W(REF_W)) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .frac_mode_i(frac_mode_i),
        .ref_freq_i(ref_freq_i), .div_word_i(div_word_i), .frac_word_i(frac_word_i),
        .freq_o(freq_o), .done_o(done_o), .err_o(err_o)
    );

    task automatic check(input string req, input longint act, input longint exp);
        vectors++;
        if (act != exp) begin
            misses++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic longint expect_val(input bit fr, input int r, input int m,
                                          input int p, input int s, input int k);
        longint mv, den, kk;
        kk = longint'($signed(k[15:0]));
        if (p == 0) return 0;
        mv  = fr ? (longint'(m) * 65536 + kk) : longint'(m);
        den = (fr ? longint'(p) * 65536 : longint'(p)) << s;
        return (longint'(r) * mv) / den;
    endfunction

    // Unused bits of both words are driven to ones (R1)
    task automatic drive(input bit fr, input int r, input int m, input int p,
                         input int s, input int k);
        frac_mode_i = fr;
        ref_freq_i  = REF_W'(r);
        div_word_i  = 32'hFFC0_0C08 | (32'(m & 1023) << 12) | (32'(p & 63) << 4) | 32'(s & 7);
        frac_word_i = 32'hA5A5_0000 | 32'(k & 16'hFFFF);
    endtask

    task automatic wait_done(output bit seen);
        seen = 1'b0;
        for (int n = 0; n < 400; n++) begin
            if (done_o) begin
                seen = 1'b1;
                break;
            end
            @(negedge clk);
        end
    endtask

    task automatic apply(input bit fr, input int r, input int m, input int p,
                         input int s, input int k, input string req);
        bit seen;
        longint exp;
        @(negedge clk);
        drive(fr, r, m, p, s, k);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        wait_done(seen);
        exp = expect_val(fr, r, m, p, s, k);
        if (!seen) begin
            check({req, " done timeout"}, 0, 1);
        end else begin
            check(req, longint'(freq_o), exp);
            check("R8 err flag", longint'(err_o), (p == 0) ? 1 : 0);
            @(negedge clk);
            check("R5 done one cycle", longint'(done_o), 0);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        misses++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        bit seen;
        int cnt;
        repeat (3) @(negedge clk);
        // R7: reset state
        check("R7 done after reset", longint'(done_o), 0);
        check("R7 err after reset", longint'(err_o), 0);
        check("R7 freq after reset", longint'(freq_o), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 with R4: every P against every S in integer mode
        for (int p = 0; p < 64; p++) begin
            for (int s = 0; s < 8; s++) begin
                apply(1'b0, (p * 7 + s * 13 + 1) % 256, (p * 37 + s * 101) % 1024,
                      p, s, (p * 911) & 16'hFFFF, (p == 0) ? "R4 zero P" : "R2 integer");
            end
        end

        // R3: fractional sweep with signed K, including M = 0
        for (int i = 0; i < 320; i++) begin
            apply(1'b1, (i * 3 + 5) % 256, (i % 16 == 0) ? 0 : (i * 13) % 1024,
                  (i * 5) % 64, (i / 40) % 8, (i * 2654) & 16'hFFFF, "R3 fractional");
        end

        // R3 corners: largest positive, negative result, zero reference
        apply(1'b1, 255, 1023, 1, 0, 16'h7FFF, "R3 max positive");
        apply(1'b1, 255, 0, 1, 0, 16'h8000, "R3 most negative fraction");
        apply(1'b1, 7, 0, 3, 2, 16'hFFFF, "R3 truncate toward zero");
        apply(1'b0, 0, 1023, 1, 0, 0, "R2 zero reference");
        apply(1'b0, 255, 1023, 63, 7, 0, "R2 largest divisor");

        // R6: start with P = 0 while busy must be ignored
        @(negedge clk);
        drive(1'b0, 200, 500, 3, 1, 0);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (3) @(negedge clk);
        check("R6 no early done", longint'(done_o), 0);
        drive(1'b0, 99, 1, 0, 0, 0);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check("R6 ignored start no done", longint'(done_o), 0);
        drive(1'b0, 0, 0, 0, 0, 0);
        wait_done(seen);
        check("R6 original done seen", longint'(seen), 1);
        check("R6 original result", longint'(freq_o), expect_val(1'b0, 200, 500, 3, 1, 0));
        check("R6 no error", longint'(err_o), 0);
        cnt = 0;
        for (int n = 0; n < 120; n++) begin
            @(negedge clk);
            if (done_o) cnt++;
        end
        check("R6 no extra done", longint'(cnt), 0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule